// File: doc/BRIEF.md
# Special Purpose Register Unit

This block holds the four special registers of a small 32-bit soft processor core: a mirror of the program counter, the machine status register (MSR), the exception status register (ESR) and the exception address register (EAR). A move-from operation selects one of the four and returns it on a result bus one cycle later, so the pipeline can write it to a destination register.

Instructions can change only the status register, in three ways. A move-to copies a whole general register value. A set ORs an immediate mask into the lower half. A clear removes the mask bits from the lower half. Side-effect strobes from break and return instructions adjust individual status bits. An exception strobe captures a status word and a faulting address and marks an exception as in progress.

The status bit positions are parameters. The defaults are: bit 1 interrupt enable, bit 3 break in progress, bit 8 exception enable, bit 9 exception in progress. A generate option chooses between a registered result port (the default) and a combinational one.

Top module: `spr_unit`

## Requirements
- R1: After reset the MSR, ESR and EAR all read as zero and `res_valid` is low.
- R2: A write whose `wr_target` is 0 (PC), 2 (ESR) or 3 (EAR) leaves every special register unchanged.
- R3: A write with `wr_target`=1 (MSR) and `wr_kind`=0 (move) copies all 32 bits of `wr_data` into the MSR.
- R4: With `wr_kind`=1 (set) the lower 16 MSR bits become `msr | wr_mask`. With `wr_kind`=2 (clear) they become `msr & ~wr_mask`. In both cases the upper 16 bits are unchanged. `wr_kind`=3 has no effect.
- R5: When `rd_en` is high, the next cycle has `res_valid` high and `res_data` set by `rd_sel`: 0 gives the current `pc_in`, 1 the MSR, 2 the ESR and 3 the EAR.
- R6: `brk_strobe` sets MSR bit 3 (break in progress).
- R7: With `ret_en` high, `ret_kind` 0 (subroutine) leaves the MSR alone. `ret_kind` 1 (interrupt) sets bit 1. `ret_kind` 2 (break) clears bit 3. `ret_kind` 3 (exception) clears bit 9 and sets bit 8.
- R8: `exc_strobe` loads the ESR from `exc_status` and the EAR from `exc_addr` in one cycle, and sets MSR bit 9.
- R9: A read of the MSR in the same cycle as an MSR write returns the value from before that write.
- R10: When several events change the MSR in one cycle, they are applied in this order: the instruction write, then the return effect, then the break set, then the exception set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_in | input | 32 | Current program counter value to mirror |
| rd_en | input | 1 | Move-from request |
| rd_sel | input | 2 | Register to read: 0 PC, 1 MSR, 2 ESR, 3 EAR |
| res_valid | output | 1 | Result valid, one cycle after rd_en |
| res_data | output | 32 | Value read |
| wr_en | input | 1 | Instruction write request |
| wr_target | input | 2 | Register addressed by the write |
| wr_kind | input | 2 | 0 move, 1 set, 2 clear, 3 none |
| wr_data | input | 32 | General register value for a move |
| wr_mask | input | 16 | Immediate mask for set and clear |
| brk_strobe | input | 1 | Break instruction side effect |
| ret_en | input | 1 | Return instruction side effect |
| ret_kind | input | 2 | 0 subroutine, 1 interrupt, 2 break, 3 exception |
| exc_strobe | input | 1 | Exception capture |
| exc_status | input | 32 | Status word to capture |
| exc_addr | input | 32 | Faulting address to capture |

## Verification
The MSR is first loaded with a word that has bits in both halves. Set and clear masks that hit both zero and one bits then show whether only the lower half moves. Writes aimed at the three read-only registers carry data that would be visible if it landed. Each return kind is applied to a status word where its target bits are in the opposite state, so a wrong or missing effect shows up. A read in the same cycle as a move-to, and one cycle with a move-to, a return, a break and an exception all at once, separate old-value reads and the order of the updates from a design that only handles one event per cycle.

// File: rtl/spr_pkg.sv
package spr_pkg;
   typedef enum logic [1:0] {
      SEL_PC  = 2'd0,
      SEL_MSR = 2'd1,
      SEL_ESR = 2'd2,
      SEL_EAR = 2'd3
   } spr_sel_e;

   typedef enum logic [1:0] {
      WK_MOVE = 2'd0,
      WK_SET  = 2'd1,
      WK_CLR  = 2'd2,
      WK_NONE = 2'd3
   } wr_kind_e;

   typedef enum logic [1:0] {
      RK_SUB = 2'd0,
      RK_INT = 2'd1,
      RK_BRK = 2'd2,
      RK_EXC = 2'd3
   } ret_kind_e;
endpackage

// File: rtl/spr_status.sv
module spr_status
   import spr_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int IE_BIT  = 1,
   parameter int BIP_BIT = 3,
   parameter int EE_BIT  = 8,
   parameter int EIP_BIT = 9,
   localparam int HALF_W = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_target,
   input  logic [1:0]        wr_kind,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [HALF_W-1:0] wr_mask,
   input  logic              brk_strobe,
   input  logic              ret_en,
   input  logic [1:0]        ret_kind,
   input  logic              exc_strobe,
   output logic [DATA_W-1:0] msr
);
   logic [DATA_W-1:0] msr_nxt;
   logic              hit;

   assign hit = wr_en && (spr_sel_e'(wr_target) == SEL_MSR);

   always_comb begin
      msr_nxt = msr;
      if (hit) begin
         case (wr_kind_e'(wr_kind))
            WK_MOVE: msr_nxt = wr_data;
            WK_SET:  msr_nxt[HALF_W-1:0] = msr[HALF_W-1:0] | wr_mask;
            WK_CLR:  msr_nxt[HALF_W-1:0] = msr[HALF_W-1:0] & ~wr_mask;
            default: ;
         endcase
      end
      if (ret_en) begin
         case (ret_kind_e'(ret_kind))
            RK_INT: msr_nxt[IE_BIT] = 1'b1;
            RK_BRK: msr_nxt[BIP_BIT] = 1'b0;
            RK_EXC: begin
               msr_nxt[EIP_BIT] = 1'b0;
               msr_nxt[EE_BIT]  = 1'b1;
            end
            default: ;
         endcase
      end
      if (brk_strobe) msr_nxt[BIP_BIT] = 1'b1;
      if (exc_strobe) msr_nxt[EIP_BIT] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) msr <= '0;
      else        msr <= msr_nxt;
   end

   // R4: only a move-to may change the upper half
   assert_upper_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit && wr_kind == 2'd0) |=> msr[DATA_W-1:HALF_W] == $past(msr[DATA_W-1:HALF_W]));

   assert_brk_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      brk_strobe |=> msr[BIP_BIT]);

   assert_exc_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exc_strobe |=> msr[EIP_BIT]);

   // R2: writes aimed elsewhere with no side effects leave the MSR alone
   assert_no_stray_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !ret_en && !brk_strobe && !exc_strobe) |=> $stable(msr));
endmodule

// File: rtl/spr_fault.sv
module spr_fault #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exc_strobe,
   input  logic [DATA_W-1:0] exc_status,
   input  logic [DATA_W-1:0] exc_addr,
   output logic [DATA_W-1:0] esr,
   output logic [DATA_W-1:0] ear
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         esr <= '0;
         ear <= '0;
      end else if (exc_strobe) begin
         esr <= exc_status;
         ear <= exc_addr;
      end
   end

   assert_exc_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exc_strobe |=> (esr == $past(exc_status)) && (ear == $past(exc_addr)));

   assert_fault_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_strobe |=> $stable(esr) && $stable(ear));
endmodule

// File: rtl/spr_rdport.sv
module spr_rdport
   import spr_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter bit RESULT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [1:0]        rd_sel,
   input  logic [DATA_W-1:0] pc_in,
   input  logic [DATA_W-1:0] msr,
   input  logic [DATA_W-1:0] esr,
   input  logic [DATA_W-1:0] ear,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data
);
   logic [DATA_W-1:0] pick;

   always_comb begin
      case (spr_sel_e'(rd_sel))
         SEL_PC:  pick = pc_in;
         SEL_MSR: pick = msr;
         SEL_ESR: pick = esr;
         default: pick = ear;
      endcase
   end

   generate
      if (RESULT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               res_valid <= 1'b0;
               res_data  <= '0;
            end else begin
               res_valid <= rd_en;
               if (rd_en) res_data <= pick;
            end
         end

         assert_rd_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en |=> res_valid);

         // R9: the captured MSR value is the one before any same-cycle write
         assert_old_msr_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_sel == 2'd1) |=> res_data == $past(msr));
      end else begin : g_comb
         assign res_valid = rd_en;
         assign res_data  = pick;
      end
   endgenerate
endmodule

// File: rtl/spr_unit.sv
module spr_unit
   import spr_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int IE_BIT     = 1,
   parameter int BIP_BIT    = 3,
   parameter int EE_BIT     = 8,
   parameter int EIP_BIT    = 9,
   parameter bit RESULT_REG = 1'b1,
   localparam int HALF_W    = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] pc_in,
   input  logic              rd_en,
   input  logic [1:0]        rd_sel,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   input  logic              wr_en,
   input  logic [1:0]        wr_target,
   input  logic [1:0]        wr_kind,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [HALF_W-1:0] wr_mask,
   input  logic              brk_strobe,
   input  logic              ret_en,
   input  logic [1:0]        ret_kind,
   input  logic              exc_strobe,
   input  logic [DATA_W-1:0] exc_status,
   input  logic [DATA_W-1:0] exc_addr
);
   generate
      if (DATA_W < 4 || DATA_W % 2 != 0) begin : g_bad_width
         $error("spr_unit: DATA_W must be even and at least 4");
      end
      if (IE_BIT >= HALF_W || BIP_BIT >= HALF_W || EE_BIT >= HALF_W || EIP_BIT >= HALF_W) begin : g_bad_bits
         $error("spr_unit: status flag bits must lie in the lower half");
      end
   endgenerate

   logic [DATA_W-1:0] msr, esr, ear;

   spr_status #(
      .DATA_W (DATA_W), .IE_BIT (IE_BIT), .BIP_BIT (BIP_BIT),
      .EE_BIT (EE_BIT), .EIP_BIT (EIP_BIT)
   ) i_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_target  (wr_target),
      .wr_kind    (wr_kind),
      .wr_data    (wr_data),
      .wr_mask    (wr_mask),
      .brk_strobe (brk_strobe),
      .ret_en     (ret_en),
      .ret_kind   (ret_kind),
      .exc_strobe (exc_strobe),
      .msr        (msr)
   );

   spr_fault #(.DATA_W (DATA_W)) i_fault (
      .clk        (clk),
      .rst_n      (rst_n),
      .exc_strobe (exc_strobe),
      .exc_status (exc_status),
      .exc_addr   (exc_addr),
      .esr        (esr),
      .ear        (ear)
   );

   spr_rdport #(.DATA_W (DATA_W), .RESULT_REG (RESULT_REG)) i_rdport (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rd_en),
      .rd_sel    (rd_sel),
      .pc_in     (pc_in),
      .msr       (msr),
      .esr       (esr),
      .ear       (ear),
      .res_valid (res_valid),
      .res_data  (res_data)
   );
endmodule

// File: tb/test_spr_unit.sv
module test_spr_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pc_in = 32'h0000_1000;
   logic        rd_en = 1'b0;
   logic [1:0]  rd_sel = 2'd0;
   logic        res_valid;
   logic [31:0] res_data;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_target = 2'd0;
   logic [1:0]  wr_kind = 2'd0;
   logic [31:0] wr_data = '0;
   logic [15:0] wr_mask = '0;
   logic        brk_strobe = 1'b0;
   logic        ret_en = 1'b0;
   logic [1:0]  ret_kind = 2'd0;
   logic        exc_strobe = 1'b0;
   logic [31:0] exc_status = '0;
   logic [31:0] exc_addr = '0;

   always #10 clk = ~clk;

   spr_unit i_spr_unit (.*);

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [31:0] m_msr = '0, m_esr = '0, m_ear = '0;

   // Apply the currently driven inputs for one cycle, updating the model.
   task automatic apply(input string tag);
      logic [31:0] v;
      if (rd_en) begin
         case (rd_sel)
            2'd0: v = pc_in;
            2'd1: v = m_msr;
            2'd2: v = m_esr;
            default: v = m_ear;
         endcase
         exp_q.push_back(v);
         tag_q.push_back(tag);
      end
      v = m_msr;
      if (wr_en && wr_target == 2'd1) begin
         if (wr_kind == 2'd0) v = wr_data;
         else if (wr_kind == 2'd1) v[15:0] = v[15:0] | wr_mask;
         else if (wr_kind == 2'd2) v[15:0] = v[15:0] & ~wr_mask;
      end
      if (ret_en) begin
         if (ret_kind == 2'd1) v[1] = 1'b1;
         else if (ret_kind == 2'd2) v[3] = 1'b0;
         else if (ret_kind == 2'd3) begin v[9] = 1'b0; v[8] = 1'b1; end
      end
      if (brk_strobe) v[3] = 1'b1;
      if (exc_strobe) begin
         v[9] = 1'b1;
         m_esr = exc_status;
         m_ear = exc_addr;
      end
      m_msr = v;
      @(negedge clk);
      rd_en = 0; wr_en = 0; brk_strobe = 0; ret_en = 0; exc_strobe = 0;
   endtask

   task automatic rd(input logic [1:0] sel, input string tag);
      rd_en = 1; rd_sel = sel;
      apply(tag);
   endtask

   task automatic wr(input logic [1:0] tgt, input logic [1:0] kind,
                     input logic [31:0] d, input logic [15:0] m, input string tag);
      wr_en = 1; wr_target = tgt; wr_kind = kind; wr_data = d; wr_mask = m;
      apply(tag);
   endtask

   task automatic ret(input logic [1:0] k, input string tag);
      ret_en = 1; ret_kind = k;
      apply(tag);
   endtask

   // Monitor: pops one expected item per valid result.
   always @(negedge clk) begin
      if (rst_n && !done && res_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL unexpected: res_valid with no pending read, data %h expected none", res_data);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (res_data !== e) begin
               errors++;
               $display("FAIL %s: res_data %h expected %h", t, res_data, e);
            end
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (res_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1: res_valid %b expected 0", res_valid);
      end
      rst_n = 1;
      @(negedge clk);
      // R1 / R5: reset values and the PC mirror
      rd(2'd0, "R5 pc");
      rd(2'd1, "R1 msr");
      rd(2'd2, "R1 esr");
      rd(2'd3, "R1 ear");
      // R3: move-to
      wr(2'd1, 2'd0, 32'hA5A5_0000, 16'h0, "R3");
      rd(2'd1, "R3 msr");
      // R4: set, clear and the unused kind
      wr(2'd1, 2'd1, 32'hFFFF_FFFF, 16'h0302, "R4");
      rd(2'd1, "R4 set");
      wr(2'd1, 2'd2, 32'h0, 16'h0102, "R4");
      rd(2'd1, "R4 clr");
      wr(2'd1, 2'd3, 32'h0, 16'hFFFF, "R4");
      rd(2'd1, "R4 none");
      // R2: writes to read-only registers
      wr(2'd0, 2'd0, 32'hDEAD_BEEF, 16'hFFFF, "R2");
      wr(2'd2, 2'd1, 32'hDEAD_BEEF, 16'hFFFF, "R2");
      wr(2'd3, 2'd0, 32'hDEAD_BEEF, 16'hFFFF, "R2");
      rd(2'd1, "R2 msr");
      rd(2'd2, "R2 esr");
      rd(2'd3, "R2 ear");
      // R6: break
      brk_strobe = 1; apply("R6");
      rd(2'd1, "R6 msr");
      // R7: the four return kinds
      ret(2'd0, "R7"); rd(2'd1, "R7 sub");
      ret(2'd1, "R7"); rd(2'd1, "R7 int");
      ret(2'd2, "R7"); rd(2'd1, "R7 brk");
      wr(2'd1, 2'd1, 32'h0, 16'h0200, "R7");
      ret(2'd3, "R7"); rd(2'd1, "R7 exc");
      // R8: exception capture
      exc_strobe = 1; exc_status = 32'h0000_0011; exc_addr = 32'h8000_0ABC;
      apply("R8");
      rd(2'd2, "R8 esr");
      rd(2'd3, "R8 ear");
      rd(2'd1, "R8 msr");
      // R9: read in the same cycle as a move-to
      rd_en = 1; rd_sel = 2'd1;
      wr(2'd1, 2'd0, 32'h1234_5678, 16'h0, "R9 old");
      rd(2'd1, "R9 new");
      // R10: all events in one cycle
      wr_en = 1; wr_target = 2'd1; wr_kind = 2'd0; wr_data = 32'h0000_0208;
      ret_en = 1; ret_kind = 2'd2; brk_strobe = 1;
      exc_strobe = 1; exc_status = 32'h5; exc_addr = 32'h44;
      apply("R10");
      rd(2'd1, "R10 msr");
      wr(2'd1, 2'd0, 32'h0000_0308, 16'h0, "R10");
      ret_en = 1; ret_kind = 2'd3; exc_strobe = 1;
      apply("R10");
      rd(2'd1, "R10 exc wins");
      pc_in = 32'h0000_2468;
      rd(2'd0, "R5 pc2");
      repeat (3) @(negedge clk);
      done = 1;
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R5: %0d results missing, expected 0", exp_q.size());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule